// File: doc/BRIEF.md
# Replaying Strobe-Driven FIFO Buffer

This block is a first-in/first-out buffer for 9-bit words. Writers and readers use active-low strobes. A word goes in on a low pulse of the write strobe and comes out during a low pulse of the read strobe. All inputs are sampled in one system clock domain, and each strobe's falling and rising transitions are detected from those samples.

Three active-low flags report the fill state: empty, full, and more than half full. A low pulse on the rewind input moves the read side back to storage location zero while the write side stays where it is. Data written once since reset can therefore be played out again from its first word.

The output bus is modelled with an enable in place of a tri-state pad. The enable is high only while a valid read strobe is held low. Depth is a power-of-two parameter, and storage is an inferred register array.

Top module: `replay_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pointers return to location zero. After that edge `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_oe`=0.
- R2: A falling edge on `wr_n` starts a write when the buffer is not full. `din` is stored on the matching rising edge of `wr_n`, and words leave in the order they were stored.
- R3: A `wr_n` pulse that starts while the buffer is full is ignored. Nothing is stored, the write pointer does not move, and `full_n` stays 0.
- R4: A `rd_n` pulse that starts while the buffer is empty is ignored. `dout_oe` stays 0 and the read pointer does not move.
- R5: `empty_n` is 0 exactly when occupancy is zero. `full_n` is 0 exactly when occupancy equals DEPTH, which is reached after DEPTH writes with no reads. The two flags are never low together.
- R6: `half_n` is 0 exactly when occupancy exceeds DEPTH/2. It falls when the write that passes DEPTH/2 completes. It rises when the read completes on the rising edge of `rd_n` that brings occupancy to DEPTH/2.
- R7: `dout_oe` is 1 only from the clock after an accepted `rd_n` falling edge until the clock after its rising edge. During that window `dout` shows the oldest unread word. Otherwise `dout` is zero.
- R8: A falling edge on `rtx_n` is accepted when `wr_n` and `rd_n` are both high in that sample and in the one before it. It sets the read pointer to location zero and leaves the write pointer unchanged. The flags then follow the new occupancy. If the write pointer sits at location zero after at least one write, the occupancy becomes DEPTH.
- R9: A falling edge on `rtx_n` while either strobe is low has no effect on the read pointer.
- R10: A write completion and a read completion in the same clock both take effect. Occupancy is unchanged and both words are handled correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rtx_n | input | 1 | Active-low rewind (retransmit) request |
| din | input | WIDTH | Write data, captured on the rising edge of `wr_n` |
| dout | output | WIDTH | Read data, zero when not enabled |
| dout_oe | output | 1 | Output enable standing in for the tri-state bus |
| empty_n | output | 1 | Low when the buffer holds no words |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| half_n | output | 1 | Low when the buffer holds more than DEPTH/2 words |

## Verification
A write completion and a read completion can fall on the same clock. The rising edges of `wr_n` and `rd_n` then move both pointers at once. The bench provokes this by lowering and raising both strobes on the same clock with one word already stored. It judges the result by the read returning the old word, the flags showing unchanged occupancy, and a later read returning the newly written word. A rewind request that lands while a read or write strobe is held low is a second collision. It is judged by the next read continuing from the current position instead of location zero.

// File: rtl/replay_fifo_pkg.sv
// Package: shared types and strobe indices for the replaying FIFO.
// Assumes all strobes are active-low and sampled in a single clock domain.
package replay_fifo_pkg;

    // Events derived from one sampled active-low strobe.
    typedef struct packed {
        logic fell;   // high-to-low between previous and current sample
        logic rose;   // low-to-high between previous and current sample
        logic idle;   // high in both previous and current sample
    } strobe_ev_t;

    localparam int STB_WR    = 0;
    localparam int STB_RD    = 1;
    localparam int STB_RT    = 2;
    localparam int STB_COUNT = 3;

endpackage

// File: rtl/fifo_strobe_sense.sv
// Module: fifo_strobe_sense
// Keeps one previous sample per active-low strobe and derives its edge events.
// Assumes the strobes are already synchronous to clk; reset treats all as high.
module fifo_strobe_sense
    import replay_fifo_pkg::*;
#(
    parameter int N = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          strobe_n,
    output strobe_ev_t [N-1:0]    ev
);

    logic [N-1:0] last_q;

    for (genvar i = 0; i < N; i++) begin : g_sense
        // Hold the previous sample of this strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) last_q[i] <= 1'b1;
            else        last_q[i] <= strobe_n[i];
        end

        // Compare previous and current samples into events.
        always_comb begin
            ev[i].fell = last_q[i] & ~strobe_n[i];
            ev[i].rose = ~last_q[i] & strobe_n[i];
            ev[i].idle = last_q[i] & strobe_n[i];
        end
    end

endmodule

// File: rtl/fifo_regfile.sv
// Module: fifo_regfile
// Register-array storage with one synchronous write port and an
// asynchronous read port. Contents are not reset.
module fifo_regfile #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store a word when a write completes.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the word at the read address.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/fifo_pointer_ctrl.sv
// Module: fifo_pointer_ctrl
// Owns the read and write pointers (each with an extra wrap bit), the
// in-progress state of each strobe, the rewind logic and the fill flags.
// Assumes DEPTH is a power of two and at least 2.
module fifo_pointer_ctrl
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_ev_t    wr_ev,
    input  strobe_ev_t    rd_ev,
    input  strobe_ev_t    rt_ev,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic          wr_commit,
    output logic          rd_active,
    output logic          is_empty,
    output logic          is_full,
    output logic          over_half
);

    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

    logic          wr_active;
    logic          rd_commit;
    logic          rt_accept;
    logic          written_q;
    logic [PW-1:0] occupancy;
    logic [PW-1:0] rewind_ptr;

    // Fill state from the pointer difference.
    always_comb begin
        occupancy = wptr - rptr;
        is_empty  = (occupancy == '0);
        is_full   = (occupancy == FULL_CNT);
        over_half = (occupancy > HALF_CNT);
    end

    // Track a write that was accepted on its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wr_active <= 1'b0;
        else if (wr_ev.fell && !is_full) wr_active <= 1'b1;
        else if (wr_ev.rose)            wr_active <= 1'b0;
    end

    // Track a read that was accepted on its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rd_active <= 1'b0;
        else if (rd_ev.fell && !is_empty) rd_active <= 1'b1;
        else if (rd_ev.rose)              rd_active <= 1'b0;
    end

    // Completion and rewind qualification.
    always_comb begin
        wr_commit = wr_active & wr_ev.rose;
        rd_commit = rd_active & rd_ev.rose;
        rt_accept = rt_ev.fell & wr_ev.idle & rd_ev.idle;
    end

    // Pick the rewind target so location zero is reached with the right wrap bit.
    always_comb begin
        rewind_ptr = '0;
        if (wptr[AW-1:0] == '0 && written_q) rewind_ptr[AW] = ~wptr[AW];
        else                                 rewind_ptr[AW] = wptr[AW];
    end

    // Advance the write pointer on each completed write.
    always_ff @(posedge clk) begin
        if (!rst_n)         wptr <= '0;
        else if (wr_commit) wptr <= wptr + PW'(1);
    end

    // Remember whether any write completed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         written_q <= 1'b0;
        else if (wr_commit) written_q <= 1'b1;
    end

    // Rewind or advance the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)         rptr <= '0;
        else if (rt_accept) rptr <= rewind_ptr;
        else if (rd_commit) rptr <= rptr + PW'(1);
    end

endmodule

// File: rtl/replay_fifo.sv
// Module: replay_fifo (top)
// Strobe-driven FIFO with rewind and active-low fill flags. Strobes are
// sampled on clk; the output bus is represented by dout plus dout_oe.
// Assumes DEPTH is a power of two, at least 2.
module replay_fifo
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rtx_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    strobe_ev_t [STB_COUNT-1:0] ev;
    logic [STB_COUNT-1:0]       strobes_n;
    logic [PW-1:0]              wptr;
    logic [PW-1:0]              rptr;
    logic                       wr_commit;
    logic                       rd_active;
    logic                       is_empty;
    logic                       is_full;
    logic                       over_half;
    logic [WIDTH-1:0]           rdata;

    // Gather strobes in index order.
    always_comb begin
        strobes_n         = '1;
        strobes_n[STB_WR] = wr_n;
        strobes_n[STB_RD] = rd_n;
        strobes_n[STB_RT] = rtx_n;
    end

    fifo_strobe_sense #(.N(STB_COUNT)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobes_n),
        .ev       (ev)
    );

    fifo_pointer_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ev     (ev[STB_WR]),
        .rd_ev     (ev[STB_RD]),
        .rt_ev     (ev[STB_RT]),
        .wptr      (wptr),
        .rptr      (rptr),
        .wr_commit (wr_commit),
        .rd_active (rd_active),
        .is_empty  (is_empty),
        .is_full   (is_full),
        .over_half (over_half)
    );

    fifo_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk   (clk),
        .we    (wr_commit),
        .waddr (wptr[AW-1:0]),
        .wdata (din),
        .raddr (rptr[AW-1:0]),
        .rdata (rdata)
    );

    // Drive the enabled output and the active-low flags.
    always_comb begin
        dout_oe = rd_active;
        dout    = rd_active ? rdata : '0;
        empty_n = ~is_empty;
        full_n  = ~is_full;
        half_n  = ~over_half;
    end

endmodule

// File: rtl/replay_fifo_chk.sv
// Module: replay_fifo_chk
// Port-level temporal checks for replay_fifo, attached with bind.
module replay_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_n,
    input logic rd_n,
    input logic rtx_n,
    input logic dout_oe,
    input logic empty_n,
    input logic full_n,
    input logic half_n
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!empty_n && full_n && half_n && !dout_oe)); // R1

    AST_FULL_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && $fell(wr_n) && rd_n && $past(rd_n)) |=> !full_n); // R3

    AST_EMPTY_IGNORES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && $fell(rd_n)) |=> !dout_oe); // R4

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n)); // R5

    AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n); // R6

    AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> !$past(rd_n)); // R7

endmodule

bind replay_fifo replay_fifo_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .rtx_n   (rtx_n),
    .dout_oe (dout_oe),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n)
);

// File: tb/sim_replay_fifo.sv
// Bench for replay_fifo: a vector table walked by one loop, then directed cases.
module sim_replay_fifo;

    localparam int DEPTH = 16;
    localparam int WIDTH = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_n = 1'b1;
    logic             rd_n = 1'b1;
    logic             rtx_n = 1'b1;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic             dout_oe;
    logic             empty_n;
    logic             full_n;
    logic             half_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    replay_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    // Entry: op(2) wdata(9) exp_oe(1) exp_q(9) exp_flags{empty_n,full_n,half_n}(3)
    // op: 0 write, 1 read, 2 rewind
    localparam int NV = 11;
    localparam logic [23:0] VEC [NV] = '{
        {2'd0, 9'h0A5, 1'b0, 9'h000, 3'b111},
        {2'd0, 9'h15A, 1'b0, 9'h000, 3'b111},
        {2'd0, 9'h033, 1'b0, 9'h000, 3'b111},
        {2'd1, 9'h000, 1'b1, 9'h0A5, 3'b111},
        {2'd2, 9'h000, 1'b0, 9'h000, 3'b111},
        {2'd1, 9'h000, 1'b1, 9'h0A5, 3'b111},
        {2'd1, 9'h000, 1'b1, 9'h15A, 3'b111},
        {2'd1, 9'h000, 1'b1, 9'h033, 3'b011},
        {2'd1, 9'h000, 1'b0, 9'h000, 3'b011},
        {2'd2, 9'h000, 1'b0, 9'h000, 3'b111},
        {2'd1, 9'h000, 1'b1, 9'h0A5, 3'b111}
    };

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    task automatic check(string tag, int got, int exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic int flags();
        return {29'd0, empty_n, full_n, half_n};
    endfunction

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rtx_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [WIDTH-1:0] d);
        @(negedge clk) wr_n = 1'b0; din = d;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(output logic oe, output logic [WIDTH-1:0] q);
        @(negedge clk) rd_n = 1'b0;
        repeat (2) @(negedge clk);
        oe = dout_oe; q = dout;
        rd_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_rewind();
        @(negedge clk) rtx_n = 1'b0;
        @(negedge clk) rtx_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic             oe;
        logic [WIDTH-1:0] q;

        // R1: reset state
        do_reset();
        check("R1 flags after reset", flags(), 3'b011);
        check("R1 oe after reset", int'(dout_oe), 0);

        // Vector table: R2 order, R4 ignored read, R8 rewind
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][23:22])
                2'd0: do_write(VEC[i][21:13]);
                2'd1: begin
                    do_read(oe, q);
                    check($sformatf("R7 vec%0d oe", i), int'(oe), int'(VEC[i][12]));
                    if (VEC[i][12]) check($sformatf("R2 vec%0d data", i), int'(q), int'(VEC[i][11:3]));
                end
                default: do_rewind();
            endcase
            check($sformatf("R8 R4 vec%0d flags", i), flags(), int'(VEC[i][2:0]));
        end

        // R1: reset mid-use
        do_write(9'h111);
        do_reset();
        check("R1 flags after reset with data", flags(), 3'b011);

        // R5 R6: fill to full
        for (int i = 0; i < DEPTH; i++) begin
            do_write(WIDTH'(i * 7 + 1));
            if (i == DEPTH/2 - 1) check("R6 half_n at DEPTH/2", int'(half_n), 1);
            if (i == DEPTH/2)     check("R6 half_n past DEPTH/2", int'(half_n), 0);
            if (i == DEPTH - 2)   check("R5 full_n before last", int'(full_n), 1);
        end
        check("R5 full after DEPTH writes", flags(), 3'b100);

        // R3: write while full is ignored
        do_write(9'h1FF);
        check("R3 still full", flags(), 3'b100);

        // Drain; R6 clears at DEPTH/2, R3 no extra word
        for (int k = 1; k <= DEPTH; k++) begin
            do_read(oe, q);
            check($sformatf("R2 drain word %0d", k), int'(q), (k - 1) * 7 + 1);
            if (k == 1)           check("R5 full_n after read", int'(full_n), 1);
            if (k == DEPTH/2 - 1) check("R6 half_n still low", int'(half_n), 0);
            if (k == DEPTH/2)     check("R6 half_n cleared", int'(half_n), 1);
        end
        check("R3 empty after DEPTH reads", flags(), 3'b011);

        // R8: rewind with write pointer back at location zero
        do_rewind();
        check("R8 rewind full", flags(), 3'b100);
        do_read(oe, q);
        check("R8 replay first word", int'(q), 1);

        // R9: rewind while read strobe low
        do_reset();
        do_write(9'h0AA); do_write(9'h0BB); do_write(9'h0CC);
        @(negedge clk) rd_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 read word", int'(dout), 9'h0AA);
        rtx_n = 1'b0;
        @(negedge clk) rtx_n = 1'b1;
        @(negedge clk) rd_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 oe off after release", int'(dout_oe), 0);
        do_read(oe, q);
        check("R9 read continues", int'(q), 9'h0BB);
        // R9: rewind while write strobe low
        @(negedge clk) wr_n = 1'b0; din = 9'h0DD;
        @(negedge clk) rtx_n = 1'b0;
        @(negedge clk) rtx_n = 1'b1;
        @(negedge clk) wr_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read(oe, q);
        check("R9 no rewind during write", int'(q), 9'h0CC);

        // R10: simultaneous completion
        do_reset();
        do_write(9'h123);
        @(negedge clk) wr_n = 1'b0; rd_n = 1'b0; din = 9'h0F0;
        repeat (2) @(negedge clk);
        check("R10 read old word", int'(dout), 9'h123);
        wr_n = 1'b1; rd_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 occupancy unchanged", flags(), 3'b111);
        do_read(oe, q);
        check("R10 new word", int'(q), 9'h0F0);
        check("R10 empty after", flags(), 3'b011);

        finish_run();
    end

endmodule